// File: doc/BRIEF.md
# Split-Write Configuration Register Bridge

This bridge sits on a 16-bit memory-mapped host bus and feeds a bank of write-only configuration registers, each twice the bus width. The host cannot write a full register in one access, so it writes two halves. The bridge keeps the lower half in a holding register. When the upper half arrives, the bridge sends the whole word downstream in one cycle, as one strobe with a register index and the joined value. The downstream registers decode the index themselves. The bridge has no readback path: a read is acknowledged and returns zero.

Addresses are byte addresses. Every access is one half-word. The register index comes from the address bits above the half-word select. Address bit 1 picks the half and address bit 0 is ignored. The host is responsible for the write order. An upper-half write always fires, using whatever lower half was last held.

Top module: `cfg_word_joiner`

## Requirements
- R1: After reset, `cfg_stb` and `bus_ack` are low, and the held lower half is zero.
- R2: Every access, read or write, is acknowledged by `bus_ack` high for exactly the one cycle after the clock edge that samples `bus_stb` high.
- R3: A write with address bit 1 = 0 stores `bus_wdata` as the lower half and produces no `cfg_stb`.
- R4: A write with address bit 1 = 1 raises `cfg_stb` for exactly the one cycle after the accepting edge.
- R5: `cfg_idx` equals address bits [6:2] of the upper-half write. Index 0 is at byte 0x00 and index 31 at byte 0x7C.
- R6: `cfg_val` is the upper-half write data in bits [31:16] and the held lower half in bits [15:0].
- R7: A read returns `bus_rdata` = 0, raises no `cfg_stb` and leaves the held lower half unchanged.
- R8: An upper-half write with no preceding lower-half write still fires, using the held lower half (zero after reset).
- R9: The held lower half stays in place across any number of upper-half writes until the next lower-half write replaces it.
- R10: Address bit 0 has no effect on index or half selection.
- R11: Accesses on consecutive cycles are each accepted, so back-to-back upper-half writes give strobes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+2 | Byte address within the register region |
| bus_wdata | input | HALF_W | Write data, one half-word |
| bus_ack | output | 1 | Access acknowledge, one cycle |
| bus_rdata | output | HALF_W | Read data, always zero |
| cfg_stb | output | 1 | Full-register write strobe |
| cfg_idx | output | IDX_W | Register index |
| cfg_val | output | 2*HALF_W | Joined register value |

## Verification
The bench builds the bridge with its default parameters: a 5-bit index and 16-bit halves. With these values every address boundary can be reached directly. This covers index 0 and index 31 at the top of the 128-byte region, and an address with bit 0 set. Because the bus is narrow, joined values with all-ones and all-zero halves are easy to build. Back-to-back accesses and a read placed between the two halves show how the holding register behaves under the orderings the host may use.

// File: rtl/cfg_join_pkg.sv
package cfg_join_pkg;

   // Kind of access seen on the host bus in one cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_READ = 2'd1,
      ACC_LOW  = 2'd2,
      ACC_HIGH = 2'd3
   } acc_kind_e;

endpackage

// File: rtl/cfg_join_decode.sv
module cfg_join_decode
   import cfg_join_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic              stb,
   input  logic              we,
   input  logic [IDX_W+1:0]  addr,
   output acc_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);

   localparam int HALF_SEL_BIT = 1;

   // Bit 0 is the byte lane within a half-word; it is not decoded
   logic unused_byte_lane;
   assign unused_byte_lane = addr[0];

   assign idx = addr[IDX_W+1:2];

   always_comb begin
      if (!stb)
         kind = ACC_NONE;
      else if (!we)
         kind = ACC_READ;
      else if (addr[HALF_SEL_BIT])
         kind = ACC_HIGH;
      else
         kind = ACC_LOW;
   end

endmodule

// File: rtl/cfg_join_hold.sv
module cfg_join_hold #(
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HALF_W-1:0] din,
   output logic [HALF_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end

   // R9: without a load the held value does not move
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/cfg_join_ack.sv
module cfg_join_ack (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic ack
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ack <= 1'b0;
      else
         ack <= stb;
   end

   // R2
   ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> ack);

   // R2
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(stb));

endmodule

// File: rtl/cfg_join_emit.sv
module cfg_join_emit #(
   parameter int IDX_W  = 5,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [IDX_W-1:0]    idx_in,
   input  logic [HALF_W-1:0]   hi_in,
   input  logic [HALF_W-1:0]   lo_in,
   output logic                stb_out,
   output logic [IDX_W-1:0]    idx_out,
   output logic [2*HALF_W-1:0] val_out
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_out <= 1'b0;
         idx_out <= '0;
         val_out <= '0;
      end else begin
         stb_out <= fire;
         if (fire) begin
            idx_out <= idx_in;
            val_out <= {hi_in, lo_in};
         end
      end
   end

   // R6: the lower half carries the value that was held at the firing edge
   lo_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> val_out[HALF_W-1:0] == $past(lo_in));

endmodule

// File: rtl/cfg_word_joiner.sv
module cfg_word_joiner
   import cfg_join_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_stb,
   input  logic                bus_we,
   input  logic [IDX_W+1:0]    bus_addr,
   input  logic [HALF_W-1:0]   bus_wdata,
   output logic                bus_ack,
   output logic [HALF_W-1:0]   bus_rdata,
   output logic                cfg_stb,
   output logic [IDX_W-1:0]    cfg_idx,
   output logic [2*HALF_W-1:0] cfg_val
);

   localparam int NUM_REGS = 1 << IDX_W;

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("cfg_word_joiner: IDX_W must be at least 1");
      end
      if (HALF_W < 1) begin : g_bad_half
         $error("cfg_word_joiner: HALF_W must be at least 1");
      end
      if (NUM_REGS < 2) begin : g_bad_count
         $error("cfg_word_joiner: register count too small");
      end
   endgenerate

   acc_kind_e         kind;
   logic [IDX_W-1:0]  dec_idx;
   logic [HALF_W-1:0] held_lo;

   cfg_join_decode #(.IDX_W(IDX_W)) u_decode (
      .stb  (bus_stb),
      .we   (bus_we),
      .addr (bus_addr),
      .kind (kind),
      .idx  (dec_idx)
   );

   cfg_join_hold #(.HALF_W(HALF_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (kind == ACC_LOW),
      .din   (bus_wdata),
      .q     (held_lo)
   );

   cfg_join_emit #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_emit (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (kind == ACC_HIGH),
      .idx_in  (dec_idx),
      .hi_in   (bus_wdata),
      .lo_in   (held_lo),
      .stb_out (cfg_stb),
      .idx_out (cfg_idx),
      .val_out (cfg_val)
   );

   cfg_join_ack u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (bus_stb),
      .ack   (bus_ack)
   );

   // No readback path
   assign bus_rdata = '0;

   // R4: a strobe only follows an upper-half write
   stb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_stb |-> $past(bus_stb && bus_we && bus_addr[1]));

   // R4
   hi_write_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_we && bus_addr[1]) |=> cfg_stb);

   // R5
   idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_stb |-> cfg_idx == $past(bus_addr[IDX_W+1:2]));

   // R6
   hi_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_stb |-> cfg_val[2*HALF_W-1:HALF_W] == $past(bus_wdata));

   // R7
   read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && !bus_we) |=> !cfg_stb);

endmodule

// File: tb/cfg_word_joiner_bench.sv
module cfg_word_joiner_bench;

   localparam int IDX_W  = 5;
   localparam int HALF_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_stb = 1'b0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_ack;
   logic [15:0] bus_rdata;
   logic        cfg_stb;
   logic [4:0]  cfg_idx;
   logic [31:0] cfg_val;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_word_joiner #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_cfg_word_joiner (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_stb   (bus_stb),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .cfg_stb   (cfg_stb),
      .cfg_idx   (cfg_idx),
      .cfg_val   (cfg_val)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // One access: drive at a falling edge, sample at the next falling edge
   task automatic access(input logic we, input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_stb = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic expect_fire(input string tag, input logic [4:0] idx, input logic [31:0] val);
      chk({tag, " ack"}, 32'(bus_ack), 32'd1);
      chk({tag, " stb"}, 32'(cfg_stb), 32'd1);
      chk({tag, " idx"}, 32'(cfg_idx), 32'(idx));
      chk({tag, " val"}, cfg_val, val);
   endtask

   task automatic t_reset();
      // R1
      chk("R1 stb after reset", 32'(cfg_stb), 32'd0);
      chk("R1 ack after reset", 32'(bus_ack), 32'd0);
      // R8: upper half alone uses reset low half of zero
      access(1'b1, 7'h0E, 16'hABCD);
      expect_fire("R8 lone upper", 5'd3, 32'hABCD_0000);
   endtask

   task automatic t_pair();
      access(1'b1, 7'h1C, 16'h1234);
      chk("R2 ack low write", 32'(bus_ack), 32'd1);
      chk("R3 no stb on low write", 32'(cfg_stb), 32'd0);
      access(1'b1, 7'h1E, 16'h5678);
      expect_fire("R4 R5 R6 pair", 5'd7, 32'h5678_1234);
      @(negedge clk);
      chk("R4 pulse one cycle", 32'(cfg_stb), 32'd0);
      chk("R2 ack one cycle", 32'(bus_ack), 32'd0);
   endtask

   task automatic t_read();
      access(1'b0, 7'h10, 16'hFFFF);
      chk("R7 read ack", 32'(bus_ack), 32'd1);
      chk("R7 read data zero", 32'(bus_rdata), 32'd0);
      chk("R7 read no stb", 32'(cfg_stb), 32'd0);
      access(1'b1, 7'h02, 16'h0000);
      expect_fire("R7 R9 low kept after read", 5'd0, 32'h0000_1234);
   endtask

   task automatic t_top_index();
      access(1'b1, 7'h7E, 16'hFFFF);
      expect_fire("R5 R9 index 31", 5'd31, 32'hFFFF_1234);
   endtask

   task automatic t_odd_addr();
      access(1'b1, 7'h41, 16'hBEEF);
      chk("R10 odd low no stb", 32'(cfg_stb), 32'd0);
      access(1'b1, 7'h43, 16'h0001);
      expect_fire("R10 odd address", 5'd16, 32'h0001_BEEF);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 7'h08; bus_wdata = 16'h00AA;
      @(negedge clk);
      chk("R11 low first no stb", 32'(cfg_stb), 32'd0);
      bus_addr = 7'h0A; bus_wdata = 16'h1111;
      @(negedge clk);
      expect_fire("R11 first strobe", 5'd2, 32'h1111_00AA);
      bus_addr = 7'h16; bus_wdata = 16'h2222;
      @(negedge clk);
      expect_fire("R11 second strobe", 5'd5, 32'h2222_00AA);
      bus_stb = 1'b0; bus_we = 1'b0;
      @(negedge clk);
      chk("R11 strobe ends", 32'(cfg_stb), 32'd0);
   endtask

   task automatic t_relow();
      // R9: a new low write replaces the held half
      access(1'b1, 7'h20, 16'h5A5A);
      access(1'b1, 7'h22, 16'hC3C3);
      expect_fire("R9 replaced low", 5'd8, 32'hC3C3_5A5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pair();
      t_read();
      t_top_index();
      t_odd_addr();
      t_back_to_back();
      t_relow();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule